// File: doc/BRIEF.md
# Prescaled Watchdog Counter

This block is a 64-bit down-counter on a small 32-bit register port that can serve either as a general timer or as the system watchdog. Software sets a prescaler and a mode in a control word, writes a 64-bit load value as two 32-bit halves, and then sets the enable bit. The live count is taken from the load value on the write that turns enable on. After that it steps down once every prescaled interval.

When the count runs out, the block does one of two things. If the watchdog select bit is set, it raises a single-cycle reset request. Otherwise it only latches a sticky expired flag. In one-shot mode the counter then stops. In any other mode it reloads and keeps running. Software refreshes the watchdog by clearing enable, rewriting the load value and setting enable again.

Top module: `wdog_timer`

## Requirements
- R1: After reset every register reads zero and `rst_req` is low.
- R2: The control word sits at offset 0x10 with these fields:
  - bit 0: enable.
  - bit 1: read-only running flag. A write to this bit has no effect.
  - bits 3:2: mode.
  - bit 4: sticky expired flag.
  - bits 15:8: prescaler.
  - All other bits read zero.
- R3: Writes to 0x14 and 0x18 set the low and high 32 bits of the load value. Reads of the same offsets return the low and high halves of the live count.
- R4: A write that sets enable while enable is clear copies the load value into the count, sets the running flag and restarts the prescaler. Writing enable again while it is already set does not reload.
- R5: While running, the count drops by one every P clocks, where P is the prescaler value, or 2 if the prescaler is below 2. The first step lands P clocks after the enabling write.
- R6: Mode 0 is one-shot. At the step that takes the count to zero, the count stays at zero and the running flag clears. The same happens at the first step if the load value is zero.
- R7: With bit 1 of the select register at 0x00 set, each expiry drives `rst_req` high for exactly the one cycle that follows the expiring step.
- R8: With select bit 1 clear, expiry leaves `rst_req` low and sets the expired flag. The flag stays set until software writes 1 to bit 4.
- R9: In any mode other than 0, expiry reloads the count from the load value and the running flag stays set.
- R10: Writing the control word with enable clear clears the running flag and freezes the count.
- R11: Reads of any offset other than 0x00, 0x10, 0x14 and 0x18 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (8) | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The bench builds the block with its default parameters: an 8-bit offset, select bit 1 and an 8-bit prescaler. The count is loaded with very small values and run at the two smallest prescale settings, so that expiry, the pulse edges, periodic reload and the clamp of prescale 0 up to 2 all fall within a few dozen clocks. A prescaler of 255 holds the count still long enough to show that rewriting enable does not reload it. The same setting shows the high half of the count in place.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int AW      = 8,
  parameter int PW      = 8,
  parameter int SEL_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          rst_req
);
  localparam logic [AW-1:0] A_SEL  = AW'(8'h00);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h10);
  localparam logic [AW-1:0] A_LO   = AW'(8'h14);
  localparam logic [AW-1:0] A_HI   = AW'(8'h18);
  localparam logic [PW-1:0] P_MIN  = PW'(2);

  logic [31:0]   sel_q;
  logic          en_q, active_q, expired_q;
  logic [1:0]    mode_q;
  logic [PW-1:0] psc_q, div_q;
  logic [63:0]   load_q, cnt_q;

  wire [PW-1:0] psc_eff = (psc_q < P_MIN) ? P_MIN : psc_q;
  wire          tick    = active_q && (div_q >= psc_eff - PW'(1));
  wire          expire  = tick && (cnt_q[63:1] == '0);
  wire          dog     = sel_q[SEL_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= '0;
      en_q      <= 1'b0;
      active_q  <= 1'b0;
      expired_q <= 1'b0;
      mode_q    <= '0;
      psc_q     <= '0;
      div_q     <= '0;
      load_q    <= '0;
      cnt_q     <= '0;
      rst_req   <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (!active_q)  div_q <= '0;
      else if (tick)  div_q <= '0;
      else            div_q <= div_q + PW'(1);

      if (tick) begin
        if (expire) begin
          rst_req   <= dog;
          expired_q <= expired_q | ~dog;
          if (mode_q == 2'd0) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
          end else begin
            cnt_q <= load_q;
          end
        end else begin
          cnt_q <= cnt_q - 64'd1;
        end
      end

      if (wr_en) begin
        case (addr)
          A_SEL:  sel_q <= wdata;
          A_LO:   load_q[31:0]  <= wdata;
          A_HI:   load_q[63:32] <= wdata;
          A_CTRL: begin
            en_q   <= wdata[0];
            mode_q <= wdata[3:2];
            psc_q  <= wdata[8 +: PW];
            if (wdata[4]) expired_q <= 1'b0;
            if (!wdata[0]) begin
              active_q <= 1'b0;
            end else if (!en_q) begin
              active_q <= 1'b1;
              cnt_q    <= load_q;
              div_q    <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_SEL:  rdata = sel_q;
      A_CTRL: begin
        rdata[0]      = en_q;
        rdata[1]      = active_q;
        rdata[3:2]    = mode_q;
        rdata[4]      = expired_q;
        rdata[8 +: PW] = psc_q;
      end
      A_LO:   rdata = cnt_q[31:0];
      A_HI:   rdata = cnt_q[63:32];
      default: rdata = '0;
    endcase
  end
endmodule

module wdog_timer_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_req,
  input logic          active,
  input logic          en,
  input logic [1:0]    mode,
  input logic          dog,
  input logic [AW-1:0] addr,
  input logic [31:0]   rdata
);
  assert_pulse_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_req_needs_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(dog));
  assert_oneshot_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && mode == 2'd0) |-> !active);
  assert_periodic_keeps_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && mode != 2'd0 && $past(en)) |-> active);
  assert_active_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> en);
  assert_hole_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != AW'(8'h00) && addr != AW'(8'h10) && addr != AW'(8'h14) && addr != AW'(8'h18))
      |-> rdata == 32'd0);
endmodule

bind wdog_timer wdog_timer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .active(active_q), .en(en_q),
  .mode(mode_q), .dog(sel_q[SEL_BIT]), .addr(addr), .rdata(rdata)
);

// File: tb/sim_wdog_timer.sv
`timescale 1ns/1ps
module sim_wdog_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req;

  wdog_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                 .wdata(wdata), .rdata(rdata), .rst_req(rst_req));

  always #10 clk = ~clk;

  typedef struct {
    bit          pin;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.pin ? {31'd0, rst_req} : rdata;
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic chk(bit pin, logic [7:0] a, logic [31:0] e, string tag);
    item_t it;
    addr = a;
    it.pin = pin; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(posedge clk); #1;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    chk(0, 8'h10, 32'h0, "R1 ctrl");
    chk(0, 8'h00, 32'h0, "R1 select");
    chk(0, 8'h14, 32'h0, "R1 count");
    chk(1, 8'h00, 32'h0, "R1 rst_req");

    // R7 R5 R6: one-shot watchdog, prescale 4, load 3
    wr(8'h00, 32'h2);
    wr(8'h14, 32'd3);
    wr(8'h18, 32'd0);
    wr(8'h10, 32'h0401);
    chk(0, 8'h10, 32'h0403, "R2 running flag set");
    chk(0, 8'h14, 32'd3, "R4 count loaded");
    step(2);
    chk(0, 8'h14, 32'd2, "R5 first step after 4 clocks");
    step(6);
    chk(1, 8'h00, 32'd0, "R7 no request before expiry");
    chk(1, 8'h00, 32'd1, "R7 request pulse");
    chk(1, 8'h00, 32'd0, "R7 pulse one cycle");
    chk(0, 8'h10, 32'h0401, "R6 running flag cleared");
    chk(0, 8'h14, 32'd0, "R6 count stays zero");

    // R5: prescale 0 clamps to 2
    wr(8'h10, 32'h0);
    wr(8'h14, 32'd2);
    wr(8'h10, 32'h0001);
    chk(1, 8'h00, 32'd0, "R5 clamp early");
    step(2);
    chk(1, 8'h00, 32'd0, "R5 clamp before expiry");
    chk(1, 8'h00, 32'd1, "R5 clamp expiry at 4 clocks");

    // R6: load zero expires at first step
    wr(8'h10, 32'h0);
    wr(8'h14, 32'd0);
    wr(8'h10, 32'h0201);
    chk(1, 8'h00, 32'd0, "R6 zero load early");
    chk(1, 8'h00, 32'd0, "R6 zero load early");
    chk(1, 8'h00, 32'd1, "R6 zero load expires first step");

    // R4 R10: no reload while enabled, refresh reloads
    wr(8'h10, 32'h0);
    wr(8'h14, 32'd10);
    wr(8'h10, 32'hFF01);
    chk(0, 8'h14, 32'd10, "R4 load");
    wr(8'h14, 32'd50);
    wr(8'h10, 32'hFF01);
    chk(0, 8'h14, 32'd10, "R4 no reload while enabled");
    wr(8'h10, 32'hFF00);
    chk(0, 8'h10, 32'hFF00, "R10 disable clears running");
    wr(8'h10, 32'hFF01);
    chk(0, 8'h14, 32'd50, "R4 refresh reloads");

    // R3: high half
    wr(8'h10, 32'h0);
    wr(8'h18, 32'hABCD);
    wr(8'h10, 32'hFF01);
    chk(0, 8'h18, 32'hABCD, "R3 high half");
    chk(0, 8'h14, 32'd50, "R3 low half");
    wr(8'h10, 32'h0);
    wr(8'h18, 32'h0);

    // R2: running flag not writable
    wr(8'h10, 32'h000E);
    chk(0, 8'h10, 32'h000C, "R2 bit1 write ignored");
    wr(8'h10, 32'h0);

    // R8: select clear
    wr(8'h00, 32'h0);
    wr(8'h14, 32'd1);
    wr(8'h10, 32'h0201);
    chk(1, 8'h00, 32'd0, "R8 no request");
    chk(1, 8'h00, 32'd0, "R8 no request");
    chk(1, 8'h00, 32'd0, "R8 no request at expiry");
    chk(0, 8'h10, 32'h0211, "R8 expired flag set");
    wr(8'h10, 32'h0010);
    chk(0, 8'h10, 32'h0, "R8 expired flag cleared");

    // R9: periodic
    wr(8'h00, 32'h2);
    wr(8'h10, 32'h0205);
    chk(1, 8'h00, 32'd0, "R9 early");
    chk(1, 8'h00, 32'd0, "R9 early");
    chk(1, 8'h00, 32'd1, "R9 first expiry");
    chk(1, 8'h00, 32'd0, "R9 gap");
    chk(1, 8'h00, 32'd1, "R9 reload and second expiry");
    chk(0, 8'h10, 32'h0207, "R9 still running");
    wr(8'h10, 32'h0);

    // R11
    chk(0, 8'h04, 32'h0, "R11 hole 0x04");
    chk(0, 8'h1C, 32'h0, "R11 hole 0x1C");
    chk(0, 8'hFF, 32'h0, "R11 hole 0xFF");

    step(3);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule